// File: doc/BRIEF.md
# Hot-Plug Expander Mirror Controller

This block lets a device drive and observe the hot-plug signals of several downstream ports without spending its own pins on them. The signals live on an external I/O expander that sits on a serial management bus. The block holds a shadow copy of the hot-plug outputs, such as indicators and slot power controls. It also holds the input image last read back, such as presence detect and attention buttons. It converts changes in either direction into whole-image transactions. These transactions are handed to a shared bus master engine through a start/done request port.

The block never polls. When any output bit differs from the shadow, it writes the complete output image. When the expander pulls its active-low interrupt line, it reads the complete input image. After a successful read it presents the new image together with a one-cycle mask of the bits that changed. Failed transactions are retried a bounded number of times and then reported through a sticky error flag. No traffic starts until the device's configuration load has finished.

Top module: `hpx_ctrl`

## Requirements
- R1: No request is issued while `cfg_done` is low. Work that becomes pending before then is kept and issued once `cfg_done` is high.
- R2: The shadow image is zero after reset. On any cycle where `out_img` differs from the shadow, one write is scheduled. Its `req_wdata` carries the full output image, not just the changed bits. If `out_img` equals the shadow, no write is scheduled.
- R3: `exp_int_n` passes through two synchronising flip-flops. A falling edge on the synchronised line schedules one read of the whole input image. So does a low level seen while no transaction is in progress.
- R4: When a write and a read are both pending, the write is issued first (`req_write`=1) and the read (`req_write`=0) after it.
- R5: If `out_img` changes one or more times while a write is in flight, exactly one further write follows. It carries the latest image.
- R6: After a read that completes without error (`eng_done`=1, `eng_err`=0), `in_img` takes `eng_rdata` one cycle later. In that same cycle `in_chg` pulses with old XOR new for one cycle. At all other times `in_chg` is zero.
- R7: When `eng_done` returns with `eng_err`=1, the same transaction is started again. This repeats up to `RETRY_MAX` extra times.
- R8: If the last permitted attempt also fails, the transaction is dropped and `in_img` is left unchanged. `err_flag` is then set and stays set until reset.
- R9: Directly after reset: `req_start`=0, `in_img`=0, `in_chg`=0 and `err_flag`=0.
- R10: At most one transaction is outstanding. `req_start` is a one-cycle pulse and is never raised between a start and its `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | Reset and configuration load finished |
| out_img | input | OUT_W | Desired hot-plug output image from port logic |
| exp_int_n | input | 1 | Asynchronous active-low expander interrupt |
| req_start | output | 1 | One-cycle start of a bus transaction |
| req_write | output | 1 | 1 = write output image, 0 = read input image; held until done |
| req_wdata | output | OUT_W | Output image carried by the write |
| eng_done | input | 1 | Engine finished the current transaction (one cycle) |
| eng_err | input | 1 | Qualifies eng_done: transaction was not acknowledged |
| eng_rdata | input | IN_W | Input image returned by a read, valid with eng_done |
| in_img | output | IN_W | Last successfully read input image |
| in_chg | output | IN_W | One-cycle mask of input bits changed by the last read |
| err_flag | output | 1 | Sticky: a transaction failed all its attempts |

## Verification
The bench builds the block with 4-bit output and input images and `RETRY_MAX`=2. With these values every output image value and every input image value can be swept: each value change is checked for exactly one whole-image write, and each input value for the correct change mask. The small retry budget makes it cheap to sweep failure counts from zero up past the limit. That sweep covers the exact attempt count, the point where the sticky error appears, and the case where the input image is left unchanged. A write whose image is changed several times while it is in flight shows that exactly one further write follows.

// File: rtl/hpx_ctrl.sv
module hpx_ctrl #(
  parameter int OUT_W     = 16,
  parameter int IN_W      = 16,
  parameter int RETRY_MAX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_done,
  input  logic [OUT_W-1:0] out_img,
  input  logic             exp_int_n,
  output logic             req_start,
  output logic             req_write,
  output logic [OUT_W-1:0] req_wdata,
  input  logic             eng_done,
  input  logic             eng_err,
  input  logic [IN_W-1:0]  eng_rdata,
  output logic [IN_W-1:0]  in_img,
  output logic [IN_W-1:0]  in_chg,
  output logic             err_flag
);
  localparam int TW = $clog2(RETRY_MAX + 1) + 1;
  localparam logic [TW-1:0] RMAX = TW'(RETRY_MAX);

  logic             s1, s2, s2_q;
  logic [OUT_W-1:0] shadow;
  logic             wr_pend, rd_pend, busy;
  logic [TW-1:0]    tries;

  wire fall     = s2_q & ~s2;
  wire changed  = shadow != out_img;
  wire go       = cfg_done & ~busy;
  wire start_wr = go & wr_pend;
  wire start_rd = go & ~wr_pend & rd_pend;
  wire lvl_rd   = ~s2 & ~busy & ~start_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s2_q <= 1'b1;
      shadow <= '0;
      wr_pend <= 1'b0; rd_pend <= 1'b0;
    end else begin
      s1 <= exp_int_n; s2 <= s1; s2_q <= s2;
      shadow  <= out_img;
      wr_pend <= start_wr ? changed : (wr_pend | changed);
      rd_pend <= start_rd ? fall : (rd_pend | fall | lvl_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; tries <= '0;
      req_start <= 1'b0; req_write <= 1'b0; req_wdata <= '0;
      in_img <= '0; in_chg <= '0; err_flag <= 1'b0;
    end else begin
      req_start <= 1'b0;
      in_chg    <= '0;
      if (start_wr || start_rd) begin
        busy <= 1'b1; tries <= '0; req_start <= 1'b1;
        req_write <= start_wr;
        if (start_wr) req_wdata <= shadow;
      end else if (busy && eng_done) begin
        if (!eng_err) begin
          busy <= 1'b0; tries <= '0;
          if (!req_write) begin
            in_img <= eng_rdata;
            in_chg <= in_img ^ eng_rdata;
          end
        end else if (tries < RMAX) begin
          tries <= tries + 1'b1; req_start <= 1'b1;
        end else begin
          busy <= 1'b0; tries <= '0; err_flag <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hpx_ctrl_chk.sv
module hpx_ctrl_chk #(
  parameter int IN_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_done,
  input logic            req_start,
  input logic            req_write,
  input logic            eng_done,
  input logic            eng_err,
  input logic [IN_W-1:0] eng_rdata,
  input logic [IN_W-1:0] in_img,
  input logic [IN_W-1:0] in_chg,
  input logic            err_flag,
  input logic            wr_pend
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (req_start) outstanding <= 1'b1;
    else if (eng_done) outstanding <= 1'b0;
  end

  a_r1_gated_by_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    req_start |-> $past(cfg_done));
  a_r4_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && !req_write && !outstanding) |-> !$past(wr_pend));
  a_r6_image_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !eng_err && !req_write) |=> in_img == $past(eng_rdata));
  a_r6_mask_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_chg) |-> $past(eng_done && !eng_err && !req_write));
  a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_start |-> !outstanding);
endmodule

bind hpx_ctrl hpx_ctrl_chk #(.IN_W(IN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .req_start(req_start),
  .req_write(req_write), .eng_done(eng_done), .eng_err(eng_err),
  .eng_rdata(eng_rdata), .in_img(in_img), .in_chg(in_chg),
  .err_flag(err_flag), .wr_pend(wr_pend)
);

// File: tb/hpx_ctrl_test.sv
module hpx_ctrl_test;
  localparam int OW = 4, IW = 4, RM = 2, LAT = 4;

  logic clk = 1'b0, rst_n = 1'b0, cfg_done = 1'b0, exp_int_n = 1'b1;
  logic [OW-1:0] out_img = '0;
  logic req_start, req_write;
  logic [OW-1:0] req_wdata;
  logic eng_done = 1'b0, eng_err = 1'b0;
  logic [IW-1:0] eng_rdata = '0;
  logic [IW-1:0] in_img, in_chg;
  logic err_flag;

  always #5 clk = ~clk;

  hpx_ctrl #(.OUT_W(OW), .IN_W(IW), .RETRY_MAX(RM)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .out_img(out_img),
    .exp_int_n(exp_int_n), .req_start(req_start), .req_write(req_write),
    .req_wdata(req_wdata), .eng_done(eng_done), .eng_err(eng_err),
    .eng_rdata(eng_rdata), .in_img(in_img), .in_chg(in_chg), .err_flag(err_flag));

  int errors = 0, checks = 0;
  int attempts = 0, wr_cnt = 0, rd_cnt = 0, nack_left = 0, nops = 0;
  logic [OW-1:0] last_w = '0;
  logic [IW-1:0] pins = '0, got_chg = '0;
  logic op0 = 1'b0, op1 = 1'b0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin : engine
    logic wr;
    forever begin
      @(negedge clk);
      eng_done = 1'b0; eng_err = 1'b0;
      if (req_start) begin
        wr = req_write;
        attempts++;
        if (nops == 0) op0 = wr; else if (nops == 1) op1 = wr;
        nops++;
        if (wr) last_w = req_wdata;
        repeat (LAT) @(negedge clk);
        eng_done = 1'b1;
        eng_rdata = pins;
        if (nack_left > 0) begin eng_err = 1'b1; nack_left--; end
        else if (wr) wr_cnt++;
        else rd_cnt++;
        @(posedge clk);
        #1 got_chg = in_chg;
      end
    end
  end

  task automatic pulse_int();
    @(negedge clk); exp_int_n = 1'b0;
    repeat (3) @(negedge clk);
    exp_int_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [OW-1:0] prev_o;
    logic [IW-1:0] prev_i;
    int w0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_start == 0 && in_img == 0 && in_chg == 0 && err_flag == 0,
        "R9 reset state", {req_start, in_img, err_flag}, 0);

    // R1 + R4: work pending before configuration done
    out_img = 4'd5; pins = 4'hA;
    pulse_int();
    repeat (20) @(negedge clk);
    chk(attempts == 0, "R1 no request before cfg_done", attempts, 0);
    cfg_done = 1'b1;
    repeat (60) @(negedge clk);
    chk(wr_cnt == 1 && rd_cnt == 1, "R1 pending work issued", wr_cnt * 10 + rd_cnt, 11);
    chk(op0 == 1'b1 && op1 == 1'b0, "R4 write before read", {op0, op1}, 2);
    chk(last_w == 4'd5, "R2 full image written", last_w, 5);
    chk(in_img == 4'hA, "R3 input image read", in_img, 10);
    chk(got_chg == 4'hA, "R6 change mask", got_chg, 10);

    // R2 sweep all output values
    prev_o = 4'd5;
    for (int v = 0; v < 16; v++) begin
      w0 = wr_cnt;
      out_img = OW'(v);
      repeat (30) @(negedge clk);
      chk(wr_cnt - w0 == ((OW'(v) != prev_o) ? 1 : 0), "R2 one write per change",
          wr_cnt - w0, (OW'(v) != prev_o) ? 1 : 0);
      chk(last_w == OW'(v), "R2 written image", last_w, v);
      prev_o = OW'(v);
    end

    // R5 changes while a write is in flight
    w0 = wr_cnt;
    out_img = 4'd1;
    repeat (2) @(negedge clk);
    out_img = 4'd2; @(negedge clk);
    out_img = 4'd3; @(negedge clk);
    out_img = 4'd7;
    repeat (60) @(negedge clk);
    chk(wr_cnt - w0 == 2, "R5 exactly one extra write", wr_cnt - w0, 2);
    chk(last_w == 4'd7, "R5 latest image sent", last_w, 7);

    // R3/R6 sweep all input values
    prev_i = in_img;
    for (int v = 0; v < 16; v++) begin
      r0 = rd_cnt;
      pins = IW'(v ^ 5);
      pulse_int();
      repeat (40) @(negedge clk);
      chk(rd_cnt - r0 == 1, "R3 one read per interrupt", rd_cnt - r0, 1);
      chk(in_img == IW'(v ^ 5), "R6 input image", in_img, v ^ 5);
      chk(got_chg == (prev_i ^ IW'(v ^ 5)), "R6 change mask", got_chg, prev_i ^ IW'(v ^ 5));
      chk(in_chg == 0, "R6 mask is a pulse", in_chg, 0);
      prev_i = in_img;
    end

    // R3 low level while idle keeps reading
    r0 = rd_cnt;
    @(negedge clk); exp_int_n = 1'b0;
    repeat (40) @(negedge clk);
    exp_int_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(rd_cnt - r0 >= 2, "R3 level low re-reads", rd_cnt - r0, 2);

    // R7/R8 sweep of failure counts
    for (int n = 0; n <= RM + 1; n++) begin
      int a0;
      prev_i = in_img;
      a0 = attempts;
      nack_left = n;
      pins = IW'(n + 8);
      pulse_int();
      repeat (80) @(negedge clk);
      chk(attempts - a0 == ((n <= RM) ? n + 1 : RM + 1), "R7 attempt count",
          attempts - a0, (n <= RM) ? n + 1 : RM + 1);
      chk(err_flag == (n > RM), "R8 error flag", err_flag, n > RM);
      chk(in_img == ((n <= RM) ? IW'(n + 8) : prev_i), "R8 image on failure",
          in_img, (n <= RM) ? n + 8 : prev_i);
      nack_left = 0;
    end
    pins = 4'h3;
    pulse_int();
    repeat (40) @(negedge clk);
    chk(err_flag == 1'b1 && in_img == 4'h3, "R8 error stays after success", err_flag, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule